// File: doc/BRIEF.md
# Cascadable Configuration Bitstream Memory Reader

This block is the read side of a write-once memory that streams a stored configuration image into a programmable-logic device. The receiving device supplies a configuration clock. On each qualifying rising edge an internal address counter advances, and the word at the current address is presented on the data pins shortly after that edge. The receiver then samples it on the following rising edge.

A mode strap chooses between two output widths. In serial mode one bit per clock leaves on pin 0, most significant bit of each stored byte first. In byte mode all eight pins carry one stored byte per clock. Every data pin has its own drive-enable output, so several devices can share one data bus. The chip-enable-out output of one device feeds the chip-enable input of the next. The images of all devices then form one continuous stream with no gap and no overlap at the hand-off.

A combined reset/output-enable pin has a polarity that is fixed when the device is built. A BUSY input stalls the counter. The image is loaded through a simple synchronous write port before streaming starts.

Top module: `cfg_stream_rom`

## Requirements
- R1: A data pin's enable is high only while chip enable is active, output enable is active and the past-terminal flag is clear. In every other state all eight enables are low.
- R2: A rising clock edge moves the read position on only while chip enable is active, output enable is active, the past-terminal flag is clear and `busy` is low. The new data is visible before the next rising edge.
- R3: While the reset/output-enable pin signals reset, the read position is held at the first stored word (bit 7 of it in serial mode) and all enables are low.
- R4: With `RST_HIGH`=1, `rst_oe`=1 means reset and `rst_oe`=0 means output enabled. With `RST_HIGH`=0 the meanings are swapped. The default is `RST_HIGH`=1.
- R5: While `ce_n` is high the read position is held at the start, the past-terminal flag is cleared and all enables are low. `standby` equals the value of `ce_n` at the most recent rising edge.
- R6: `ceo_n` is low exactly when chip enable is active, output enable is active and the past-terminal flag is set. It goes high in the same cycle that either enable drops.
- R7: While `busy` is high the read position does not move and the data pins keep their present value.
- R8: With `par_mode`=0 (serial), only pin 0 is enabled. It carries bit 7 down to bit 0 of each stored byte on successive advancing edges, and the byte address steps after bit 0. Pins 1 to 7 stay disabled.
- R9: With `par_mode`=1 (byte), all eight pins are enabled together. They carry the stored byte, bit i on pin i, and the address steps once per advancing edge.
- R10: The advancing edge that leaves the last valid word (address `TERM_CNT`, after its bit 0 in serial mode) sets a sticky past-terminal flag. Only reset or `ce_n` high clears that flag.
- R11: When two devices are chained through `ceo_n` to `ce_n`, sharing clock and bus, the bus carries the first image followed at once by the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| ce_n | input | 1 | Chip enable, active low |
| rst_oe | input | 1 | Combined reset / output enable, polarity set by `RST_HIGH` |
| busy | input | 1 | Stall: high freezes the read position |
| par_mode | input | 1 | Output width strap: 0 serial, 1 byte |
| wr_en | input | 1 | Image load strobe |
| wr_addr | input | AW | Image load address |
| wr_data | input | 8 | Image load byte |
| d_out | output | 8 | Data pin values |
| d_en | output | 8 | Per-pin drive enable (low means high impedance) |
| ceo_n | output | 1 | Chip-enable-out for the next device, active low |
| standby | output | 1 | Registered standby indication |

## Verification
Two cases can land in the same cycle: a BUSY stall and the arrival at the terminal word. In the other case, the last bit of the first device and the first bit of the second device meet at the chained hand-off. The bench raises `busy` on the very cycle the counter sits on the last word. It checks that the word is held and that the flag is not set until `busy` falls. A serial run captures the shared bus on pin 0 across the hand-off. The bench compares the capture with the two images joined end to end, and every cycle is also compared with a behavioural model of all devices.

// File: rtl/cfg_rom_pkg.sv
package cfg_rom_pkg;
  localparam int BYTE_W = 8;
  localparam int BIT_SEL_W = $clog2(BYTE_W);

  typedef enum logic {
    OUT_SERIAL = 1'b0,
    OUT_BYTE   = 1'b1
  } out_mode_e;
endpackage

// File: rtl/cfg_rom_store.sv
module cfg_rom_store #(
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  // single write port, single registered read port: maps to block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/cfg_rom_ctrl.sv
module cfg_rom_ctrl #(
  parameter bit RST_HIGH = 1'b1
) (
  input  logic clk,
  input  logic ce_n,
  input  logic rst_oe,
  output logic chip_act,
  output logic out_act,
  output logic hold,
  output logic standby
);
  // the combined pin is reset in one level and output enable in the other
  generate
    if (RST_HIGH) begin : g_rst_high
      assign out_act = ~rst_oe;
    end else begin : g_rst_low
      assign out_act = rst_oe;
    end
  endgenerate

  assign chip_act = ~ce_n;
  assign hold     = ~chip_act | ~out_act;

  always_ff @(posedge clk) standby <= ce_n;
endmodule

// File: rtl/cfg_rom_seq.sv
module cfg_rom_seq
  import cfg_rom_pkg::*;
#(
  parameter int AW       = 6,
  parameter int TERM_CNT = 63
) (
  input  logic                 clk,
  input  logic                 hold,
  input  logic                 busy,
  input  logic                 par_mode,
  output logic [AW-1:0]        addr_q,
  output logic [AW-1:0]        addr_nxt,
  output logic [BIT_SEL_W-1:0] bit_q,
  output logic                 past_q
);
  localparam logic [AW-1:0]        TC_A     = AW'(TERM_CNT);
  localparam logic [BIT_SEL_W-1:0] LAST_BIT = BIT_SEL_W'(BYTE_W - 1);

  logic [BIT_SEL_W-1:0] bit_nxt;
  logic                 past_nxt;
  logic                 word_done;

  assign word_done = (par_mode == OUT_BYTE) || (bit_q == LAST_BIT);

  always_comb begin
    addr_nxt = addr_q;
    bit_nxt  = bit_q;
    past_nxt = past_q;
    if (hold) begin
      addr_nxt = '0;
      bit_nxt  = '0;
      past_nxt = 1'b0;
    end else if (!past_q && !busy) begin
      if (word_done) begin
        bit_nxt = '0;
        if (addr_q == TC_A) past_nxt = 1'b1;
        else                addr_nxt = addr_q + 1'b1;
      end else begin
        bit_nxt = bit_q + 1'b1;
      end
    end
  end

  // hold is the synchronous active-high reset of this state
  always_ff @(posedge clk) begin
    addr_q <= addr_nxt;
    bit_q  <= bit_nxt;
    past_q <= past_nxt;
  end

  AST_HOLD_CLEARS: assert property (@(posedge clk)
    hold |=> (addr_q == '0 && bit_q == '0 && !past_q)); // R3
  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (hold)
    busy |=> ($stable(addr_q) && $stable(bit_q))); // R7
  AST_PAST_STICKY: assert property (@(posedge clk) disable iff (hold)
    past_q |=> past_q); // R10
  AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (hold)
    addr_q <= TC_A); // R10
endmodule

// File: rtl/cfg_rom_outmux.sv
module cfg_rom_outmux
  import cfg_rom_pkg::*;
(
  input  logic [BYTE_W-1:0]    rd_byte,
  input  logic [BIT_SEL_W-1:0] bit_sel,
  input  logic                 par_mode,
  input  logic                 drive,
  output logic [BYTE_W-1:0]    d_out,
  output logic [BYTE_W-1:0]    d_en
);
  logic serial_bit;
  logic is_byte;

  assign is_byte    = (par_mode == OUT_BYTE);
  // most significant bit of each stored byte leaves first
  assign serial_bit = rd_byte[BIT_SEL_W'(BYTE_W - 1) - bit_sel];

  generate
    for (genvar g = 0; g < BYTE_W; g++) begin : g_pin
      if (g == 0) begin : g_lsb
        assign d_out[g] = is_byte ? rd_byte[g] : serial_bit;
        assign d_en[g]  = drive;
      end else begin : g_upper
        assign d_out[g] = is_byte & rd_byte[g];
        assign d_en[g]  = drive & is_byte;
      end
    end
  endgenerate
endmodule

// File: rtl/cfg_stream_rom.sv
module cfg_stream_rom
  import cfg_rom_pkg::*;
#(
  parameter int  DEPTH    = 64,
  parameter int  TERM_CNT = DEPTH - 1,
  parameter bit  RST_HIGH = 1'b1,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              ce_n,
  input  logic              rst_oe,
  input  logic              busy,
  input  logic              par_mode,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] d_out,
  output logic [BYTE_W-1:0] d_en,
  output logic              ceo_n,
  output logic              standby
);
  logic                 chip_act, out_act, hold;
  logic [AW-1:0]        addr_q, addr_nxt;
  logic [BIT_SEL_W-1:0] bit_q;
  logic                 past_q;
  logic [BYTE_W-1:0]    rd_byte;
  logic                 drive;

  cfg_rom_ctrl #(.RST_HIGH(RST_HIGH)) u_ctrl (
    .clk(clk), .ce_n(ce_n), .rst_oe(rst_oe),
    .chip_act(chip_act), .out_act(out_act), .hold(hold), .standby(standby)
  );

  cfg_rom_seq #(.AW(AW), .TERM_CNT(TERM_CNT)) u_seq (
    .clk(clk), .hold(hold), .busy(busy), .par_mode(par_mode),
    .addr_q(addr_q), .addr_nxt(addr_nxt), .bit_q(bit_q), .past_q(past_q)
  );

  // read address is the next position so the word is ready right after the edge
  cfg_rom_store #(.DEPTH(DEPTH), .AW(AW), .DW(BYTE_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(addr_nxt), .rd_data(rd_byte)
  );

  assign drive = chip_act & out_act & ~past_q;
  assign ceo_n = ~(chip_act & out_act & past_q);

  cfg_rom_outmux u_outmux (
    .rd_byte(rd_byte), .bit_sel(bit_q), .par_mode(par_mode), .drive(drive),
    .d_out(d_out), .d_en(d_en)
  );

  AST_CEO_QUIET: assert property (@(posedge clk) disable iff (hold)
    !ceo_n |-> (d_en == '0)); // R6
  AST_SERIAL_PINS: assert property (@(posedge clk) disable iff (hold)
    (par_mode == OUT_SERIAL) |-> (d_en[BYTE_W-1:1] == '0)); // R8
  AST_BYTE_PINS: assert property (@(posedge clk) disable iff (hold)
    (par_mode == OUT_BYTE) |-> (d_en == '0 || d_en == '1)); // R9
  AST_IDLE_HIZ: assert property (@(posedge clk)
    hold |-> (d_en == '0 && ceo_n)); // R1
endmodule

// File: tb/test_cfg_stream_rom.sv
module test_cfg_stream_rom;
  localparam int DEPTH = 8;
  localparam int TC0   = 5;
  localparam int TC2   = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic ce_n0, rst0, busy, par, ce_n2, rst2, busy2, par2;
  logic we0, we1, we2;
  logic [2:0] wa;
  logic [7:0] wd;
  logic [7:0] o0, o1, o2, e0, e1, e2;
  logic c0, c1, c2, s0, s1, s2;

  cfg_stream_rom #(.DEPTH(DEPTH), .TERM_CNT(TC0), .RST_HIGH(1'b1)) i_cfg_stream_rom (
    .clk(clk), .ce_n(ce_n0), .rst_oe(rst0), .busy(busy), .par_mode(par),
    .wr_en(we0), .wr_addr(wa), .wr_data(wd),
    .d_out(o0), .d_en(e0), .ceo_n(c0), .standby(s0));
  cfg_stream_rom #(.DEPTH(DEPTH), .TERM_CNT(TC0), .RST_HIGH(1'b1)) i_cfg_stream_rom_b (
    .clk(clk), .ce_n(c0), .rst_oe(rst0), .busy(busy), .par_mode(par),
    .wr_en(we1), .wr_addr(wa), .wr_data(wd),
    .d_out(o1), .d_en(e1), .ceo_n(c1), .standby(s1));
  cfg_stream_rom #(.DEPTH(DEPTH), .TERM_CNT(TC2), .RST_HIGH(1'b0)) i_cfg_stream_rom_c (
    .clk(clk), .ce_n(ce_n2), .rst_oe(rst2), .busy(busy2), .par_mode(par2),
    .wr_en(we2), .wr_addr(wa), .wr_data(wd),
    .d_out(o2), .d_en(e2), .ceo_n(c2), .standby(s2));

  logic [7:0] a_out [3];
  logic [7:0] a_en  [3];
  logic       a_ceo [3];
  logic       a_sby [3];
  assign a_out[0] = o0; assign a_out[1] = o1; assign a_out[2] = o2;
  assign a_en[0]  = e0; assign a_en[1]  = e1; assign a_en[2]  = e2;
  assign a_ceo[0] = c0; assign a_ceo[1] = c1; assign a_ceo[2] = c2;
  assign a_sby[0] = s0; assign a_sby[1] = s1; assign a_sby[2] = s2;

  int n_chk = 0, n_bad = 0;
  bit checking = 0, collecting = 0, started = 0;
  bit stream_q[$];

  function automatic logic [7:0] img(int k, int i);
    case (k)
      0:       return 8'(8'hA5 ^ (i * 37));
      1:       return 8'(8'h3C + i * 19);
      default: return 8'(i * 71 + 5);
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model, one entry per device
  int m_addr [3];
  int m_bit  [3];
  bit m_past [3];
  bit m_sby  [3];

  function automatic bit oe_of(int k);
    return (k == 2) ? rst2 : !rst0;
  endfunction
  function automatic bit ce_of(int k);
    if (k == 0) return !ce_n0;
    if (k == 2) return !ce_n2;
    return !ce_n0 && !rst0 && m_past[0];
  endfunction

  always @(posedge clk) begin
    bit ce_v [3];
    for (int k = 0; k < 3; k++) ce_v[k] = ce_of(k);
    for (int k = 0; k < 3; k++) begin
      bit bz, pm;
      int tc;
      bz = (k == 2) ? busy2 : busy;
      pm = (k == 2) ? par2 : par;
      tc = (k == 2) ? TC2 : TC0;
      m_sby[k] = !ce_v[k];
      if (!ce_v[k] || !oe_of(k)) begin
        m_addr[k] = 0; m_bit[k] = 0; m_past[k] = 0;
      end else if (!m_past[k] && !bz) begin
        if (pm || m_bit[k] == 7) begin
          m_bit[k] = 0;
          if (m_addr[k] == tc) m_past[k] = 1;
          else m_addr[k]++;
        end else m_bit[k]++;
      end
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && checking) begin
      for (int k = 0; k < 3; k++) begin
        bit ce, oe, drv, pm;
        logic [7:0] b, xen, xout;
        ce = ce_of(k); oe = oe_of(k);
        pm = (k == 2) ? par2 : par;
        drv = ce && oe && !m_past[k];
        b = img(k, m_addr[k]);
        xen  = !drv ? 8'h00 : (pm ? 8'hFF : 8'h01);
        xout = pm ? b : {7'b0, b[7 - m_bit[k]]};
        chk(a_en[k] === xen, "R1", $sformatf("dev%0d enables", k), int'(a_en[k]), int'(xen));
        chk((a_out[k] & xen) === (xout & xen), pm ? "R9" : "R8",
            $sformatf("dev%0d data", k), int'(a_out[k] & xen), int'(xout & xen));
        chk(a_ceo[k] === !(ce && oe && m_past[k]), "R6",
            $sformatf("dev%0d ceo_n", k), int'(a_ceo[k]), int'(!(ce && oe && m_past[k])));
        chk(a_sby[k] === m_sby[k], "R5", $sformatf("dev%0d standby", k),
            int'(a_sby[k]), int'(m_sby[k]));
      end
      if (collecting && (e0[0] || e1[0])) stream_q.push_back(e0[0] ? o0[0] : o1[0]);
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++; n_chk++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    ce_n0 = 1; rst0 = 1; busy = 0; par = 0;
    ce_n2 = 1; rst2 = 0; busy2 = 0; par2 = 1;
    we0 = 0; we1 = 0; we2 = 0; wa = '0; wd = '0;
    #3;
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < DEPTH; i++) begin
        we0 = (k == 0); we1 = (k == 1); we2 = (k == 2);
        wa = 3'(i); wd = img(k, i);
        step(1);
      end
    end
    we0 = 0; we1 = 0; we2 = 0;
    step(2);
    checking = 1;
    // R3 and R5: held state before any release
    chk(e0 == 8'h00 && e1 == 8'h00, "R3", "enables under reset", int'(e0 | e1), 0);
    chk(s0 === 1'b1 && c0 === 1'b1, "R5", "standby/ceo_n with ce_n high", int'({s0, c0}), 3);

    // R11: serial chained stream across the hand-off
    collecting = 1;
    ce_n0 = 0; rst0 = 0;
    step(110);
    collecting = 0;
    chk(stream_q.size() == 2 * (TC0 + 1) * 8, "R11", "stream length",
        stream_q.size(), 2 * (TC0 + 1) * 8);
    for (int j = 0; j < stream_q.size() && j < 2 * (TC0 + 1) * 8; j++) begin
      logic [7:0] b;
      b = (j < (TC0 + 1) * 8) ? img(0, j / 8) : img(1, (j - (TC0 + 1) * 8) / 8);
      chk(stream_q[j] === b[7 - (j % 8)], "R11", $sformatf("stream bit %0d", j),
          int'(stream_q[j]), int'(b[7 - (j % 8)]));
    end
    // R10: both devices past terminal, bus released and stays released
    chk(e0 == 8'h00 && e1 == 8'h00 && c1 === 1'b0, "R10", "after both images",
        int'({e0 | e1, c1}), 0);
    step(4);
    chk(e0 == 8'h00 && c0 === 1'b0, "R10", "flag sticky", int'({e0, c0}), 0);

    // R3: reset mid-stream restarts at word 0
    rst0 = 1; step(2); rst0 = 0; step(5);
    busy = 1; step(4); busy = 0; step(3);
    ce_n0 = 1; step(2); ce_n0 = 0; step(10);

    // R2/R9: byte mode from reset
    rst0 = 1; step(1); par = 1; rst0 = 0;
    step(3);
    chk(e0 == 8'hFF && o0 == img(0, 3), "R2", "byte address after 3 edges",
        int'(o0), int'(img(0, 3)));
    step(2);
    // R7: busy on the cycle the counter sits on the last word
    busy = 1; step(3);
    chk(e0 == 8'hFF && o0 == img(0, TC0) && c0 === 1'b1, "R7", "held at terminal word",
        int'(o0), int'(img(0, TC0)));
    busy = 0; step(1);
    chk(e0 == 8'h00 && e1 == 8'hFF && o1 == img(1, 0), "R11", "byte hand-off",
        int'(o1), int'(img(1, 0)));
    step(3);
    busy = 1; step(2); busy = 0; step(6);
    rst0 = 1; step(1);
    // R6: ceo_n returns high immediately with output enable
    chk(c0 === 1'b1 && c1 === 1'b1, "R6", "ceo_n release", int'({c0, c1}), 3);
    rst0 = 0; step(2);

    // R4: inverted polarity device, low pin is reset
    ce_n2 = 0; rst2 = 0; step(2);
    chk(e2 == 8'h00, "R4", "low pin holds reset", int'(e2), 0);
    rst2 = 1; step(3);
    chk(e2 == 8'hFF && o2 == img(2, 3), "R4", "high pin enables output", int'(o2), int'(img(2, 3)));
    step(1);
    chk(e2 == 8'h00 && c2 === 1'b0, "R10", "short image past terminal", int'({e2, c2}), 0);
    par2 = 0; rst2 = 0; step(1); rst2 = 1; step(12);
    step(2);
    checking = 0;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule